// File: doc/BRIEF.md
# Memory CRC32 Scanner with Golden Compare

The scanner walks a contiguous region of a 32-bit-wide ROM, fetching one word per request, and folds each word into a running CRC-32. Software programs a base address, a block-size code, a seed and an expected (golden) value through a small word-addressed register port. It then writes the start bit. The scan runs without further help. It can be frozen and resumed with a halt bit, and it pauses on an external debug-suspend input unless free-run mode is chosen.

When the last word has been folded in, the result is compared with the golden value and a pass/fail bit is stored. A done event flag is set, and when its enable is on it sets a global interrupt latch that drives the interrupt output. Software clears the flag and re-arms the latch with write-one-to-clear bits, and can set the flag on purpose through a force bit.

Register map (word index on `reg_addr`): 0 control, 1 base address, 2 seed, 3 status, 4 result, 5 golden, 6 interrupt enable, 7 flags, 8 clear, 9 force.

Top module: `crc32_rom_scanner`

## Requirements
- R1: Control bits [14:8] hold a size code N, and a scan covers (N+1)*WORDS_PER_KB words. The words are fetched in increasing order at byte addresses base + 4*i, i = 0, 1, ...
- R2: If (N+1)*WORDS_PER_KB exceeds ROM_WORDS, the scan covers exactly ROM_WORDS words.
- R3: Writing 1 to control bit 0 (start) copies the seed register (index 2) into the CRC and begins a scan. Writing 0 there starts nothing, and bit 0 always reads back as 0.
- R4: A start written during a scan abandons it, reloads the seed and scans again from the base address. Data still in flight from the old scan is discarded.
- R5: While control bit 1 (halt) is 1 during a scan, no fetch is issued and the position holds. Clearing it resumes from the same word, and the final CRC equals that of an unbroken scan.
- R6: With control bit 2 (free) at 0, a high `dbg_suspend` pauses the scan as halt does. With free at 1, `dbg_suspend` is ignored.
- R7: Status (index 3) bit 0 is 1 while a scan runs and 0 when idle. Bits [31:16] give the number of words issued so far in the current scan, which equals the scan length at the end.
- R8: Status bit 1 is updated only when a scan completes: 0 if the result equals golden (index 5), 1 otherwise. The result register (index 4) then holds the final CRC.
- R9: Completion sets flag bit 0 (done, index 7). When done and enable (index 6 bit 0) are both 1, flag bit 1 (global) sets and stays set. `irq` equals the global bit.
- R10: Writing 1 to clear bit 0 (index 8) clears done. Writing 1 to clear bit 1 clears the global latch, which re-fires if done and enable are still set. Writing 1 to force bit 0 (index 9) sets done.
- R11: The CRC uses polynomial 0x04C11DB7, consumes each 32-bit word MSB first, and applies no final XOR.
- R12: Halt writes made while no scan is running are ignored, so control bit 1 reads 0. A completed scan also clears halt.
- R13: The fetch port issues `rom_addr` with `rom_req`. A request is accepted when `rom_ready` is high, and `rom_rdata` is taken on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rom_req | output | 1 | Fetch request valid |
| rom_addr | output | 32 | Fetch byte address |
| rom_ready | input | 1 | ROM accepts the request this cycle |
| rom_rdata | input | 32 | ROM data, one cycle after acceptance |
| dbg_suspend | input | 1 | Debug suspend request |
| irq | output | 1 | Interrupt (global latch) |

## Verification
The bench builds the block with WORDS_PER_KB = 8 and ROM_WORDS = 32. Whole scans therefore last tens of cycles, and size codes 3 and above all land on the clamp. Codes 9 and 127 show that the clamp holds far past the limit. A bench ROM with an optional one-in-three stall pattern exercises back-pressure, and restart, halt, suspend and interrupt sequences are directed around mid-scan positions.

// File: rtl/crc32_scan_pkg.sv
package crc32_scan_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  localparam logic [3:0] RA_CTRL = 4'd0;
  localparam logic [3:0] RA_BASE = 4'd1;
  localparam logic [3:0] RA_SEED = 4'd2;
  localparam logic [3:0] RA_STAT = 4'd3;
  localparam logic [3:0] RA_RES  = 4'd4;
  localparam logic [3:0] RA_GOLD = 4'd5;
  localparam logic [3:0] RA_IEN  = 4'd6;
  localparam logic [3:0] RA_FLAG = 4'd7;
  localparam logic [3:0] RA_CLR  = 4'd8;
  localparam logic [3:0] RA_FRC  = 4'd9;

  // one 32-bit word folded into the CRC, MSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  // scan length in words after clamping to the ROM size
  function automatic int unsigned scan_words(input logic [6:0] code, input int unsigned wpk,
                                             input int unsigned rom_words);
    int unsigned want;
    want = (int'(code) + 1) * wpk;
    return (want > rom_words) ? rom_words : want;
  endfunction
endpackage

// File: rtl/crc32_fetch_seq.sv
module crc32_fetch_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pause,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  input  logic              rom_ready,
  output logic              rom_req,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              running,
  output logic              beat,
  output logic              last_beat,
  output logic [CNT_W-1:0]  issued,
  output logic [CNT_W-1:0]  scan_len
);
  logic [CNT_W-1:0]  taken_q;
  logic [ADDR_W-1:0] base_q;
  logic              pend_q;
  logic              accept;

  assign rom_req   = running && !pause && (issued != scan_len);
  assign accept    = rom_req && rom_ready;
  assign rom_addr  = base_q + (ADDR_W'(issued) << 2);
  assign beat      = pend_q;
  assign last_beat = pend_q && ((taken_q + CNT_W'(1)) == scan_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      issued   <= '0;
      taken_q  <= '0;
      pend_q   <= 1'b0;
      base_q   <= '0;
      scan_len <= '0;
    end else if (start) begin
      running  <= 1'b1;
      issued   <= '0;
      taken_q  <= '0;
      pend_q   <= 1'b0;
      base_q   <= base;
      scan_len <= len;
    end else begin
      pend_q <= accept;
      if (accept)    issued  <= issued + CNT_W'(1);
      if (pend_q)    taken_q <= taken_q + CNT_W'(1);
      if (last_beat) running <= 1'b0;
    end
  end
endmodule

// File: rtl/crc32_datapath.sv
module crc32_datapath
  import crc32_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] seed,
  input  logic        beat,
  input  logic        last_beat,
  input  logic [31:0] data,
  input  logic [31:0] golden,
  output logic [31:0] crc_q,
  output logic        fail_q
);
  logic [31:0] crc_next;
  assign crc_next = crc_step(crc_q, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      if (start)     crc_q <= seed;
      else if (beat) crc_q <= crc_next;
      if (!start && last_beat) fail_q <= (crc_next != golden);
    end
  end
endmodule

// File: rtl/crc32_irq_ctl.sv
module crc32_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic force_done,
  input  logic clr_done,
  input  logic clr_glb,
  input  logic done_en,
  output logic done_flag,
  output logic glb_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      glb_flag  <= 1'b0;
    end else begin
      if (done_evt || force_done) done_flag <= 1'b1;
      else if (clr_done)          done_flag <= 1'b0;
      if (clr_glb)                      glb_flag <= 1'b0;
      else if (done_flag && done_en)    glb_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/crc32_rom_scanner.sv
module crc32_rom_scanner
  import crc32_scan_pkg::*;
#(
  parameter int WORDS_PER_KB = 256,
  parameter int ROM_WORDS    = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rom_req,
  output logic [31:0] rom_addr,
  input  logic        rom_ready,
  input  logic [31:0] rom_rdata,
  input  logic        dbg_suspend,
  output logic        irq
);
  localparam int CNT_W = $clog2(ROM_WORDS + 1);
  localparam int POS_W = 16;

  logic        halt_q, free_q, done_en;
  logic [6:0]  size_q;
  logic [31:0] base_q, seed_q, gold_q;

  logic             start_pulse, pause, running, beat, last_beat;
  logic             fail_q, done_flag, glb_flag;
  logic [31:0]      crc_q;
  logic [CNT_W-1:0] issued, scan_len, new_len;
  logic [POS_W-1:0] pos;

  logic wr_ctrl, wr_clr, wr_frc;
  assign wr_ctrl     = reg_wr && (reg_addr == RA_CTRL);
  assign wr_clr      = reg_wr && (reg_addr == RA_CLR);
  assign wr_frc      = reg_wr && (reg_addr == RA_FRC);
  assign start_pulse = wr_ctrl && reg_wdata[0];
  assign new_len     = CNT_W'(scan_words(reg_wdata[14:8], WORDS_PER_KB, ROM_WORDS));
  assign pause       = halt_q || (!free_q && dbg_suspend);
  assign pos         = POS_W'(issued);
  assign irq         = glb_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0; free_q <= 1'b0; size_q <= '0; done_en <= 1'b0;
      base_q <= '0;   seed_q <= '0;   gold_q <= '0;
    end else begin
      if (wr_ctrl) begin
        free_q <= reg_wdata[2];
        size_q <= reg_wdata[14:8];
        halt_q <= running && !reg_wdata[0] && reg_wdata[1];
      end else if (last_beat) begin
        halt_q <= 1'b0;
      end
      if (reg_wr && reg_addr == RA_BASE) base_q  <= reg_wdata;
      if (reg_wr && reg_addr == RA_SEED) seed_q  <= reg_wdata;
      if (reg_wr && reg_addr == RA_GOLD) gold_q  <= reg_wdata;
      if (reg_wr && reg_addr == RA_IEN)  done_en <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata = {17'd0, size_q, 5'd0, free_q, halt_q, 1'b0};
      RA_BASE: reg_rdata = base_q;
      RA_SEED: reg_rdata = seed_q;
      RA_STAT: reg_rdata = {pos, 14'd0, fail_q, running};
      RA_RES:  reg_rdata = crc_q;
      RA_GOLD: reg_rdata = gold_q;
      RA_IEN:  reg_rdata = {31'd0, done_en};
      RA_FLAG: reg_rdata = {30'd0, glb_flag, done_flag};
      default: reg_rdata = '0;
    endcase
  end

  crc32_fetch_seq #(.ADDR_W(32), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .pause(pause),
    .base(base_q), .len(new_len), .rom_ready(rom_ready),
    .rom_req(rom_req), .rom_addr(rom_addr), .running(running),
    .beat(beat), .last_beat(last_beat), .issued(issued), .scan_len(scan_len)
  );

  crc32_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .seed(seed_q),
    .beat(beat), .last_beat(last_beat), .data(rom_rdata), .golden(gold_q),
    .crc_q(crc_q), .fail_q(fail_q)
  );

  crc32_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .done_evt(last_beat && !start_pulse),
    .force_done(wr_frc && reg_wdata[0]), .clr_done(wr_clr && reg_wdata[0]),
    .clr_glb(wr_clr && reg_wdata[1]), .done_en(done_en),
    .done_flag(done_flag), .glb_flag(glb_flag)
  );
endmodule

// File: rtl/crc32_scan_checker.sv
module crc32_scan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_pulse,
  input logic [31:0]      seed_q,
  input logic [31:0]      crc_q,
  input logic             running,
  input logic             halt_q,
  input logic             free_q,
  input logic             dbg_suspend,
  input logic             rom_req,
  input logic             last_beat,
  input logic             done_flag,
  input logic             done_en,
  input logic             irq,
  input logic             fail_q,
  input logic [CNT_W-1:0] issued,
  input logic [CNT_W-1:0] scan_len
);
  AST_SEED_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (crc_q == $past(seed_q))); // R3

  AST_HALT_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !rom_req); // R5

  AST_SOFT_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_q && dbg_suspend) |-> !rom_req); // R6

  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rom_req); // R7

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    issued <= scan_len); // R1

  AST_VERDICT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fail_q) |-> $past(last_beat)); // R8

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start_pulse) |=> done_flag); // R9

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_flag && done_en)); // R9
endmodule

bind crc32_rom_scanner crc32_scan_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .seed_q(seed_q),
  .crc_q(crc_q), .running(running), .halt_q(halt_q), .free_q(free_q),
  .dbg_suspend(dbg_suspend), .rom_req(rom_req), .last_beat(last_beat),
  .done_flag(done_flag), .done_en(done_en), .irq(irq), .fail_q(fail_q),
  .issued(issued), .scan_len(scan_len)
);

// File: tb/crc32_rom_scanner_tb.sv
`timescale 1ns/1ps
module crc32_rom_scanner_tb;
  localparam int WPK  = 8;
  localparam int ROMW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rom_req;
  logic [31:0] rom_addr;
  logic        rom_ready;
  logic [31:0] rom_rdata = '0;
  logic        dbg_suspend = 1'b0;
  logic        irq;
  logic        stall_on = 1'b0;
  int unsigned tick = 0;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  crc32_rom_scanner #(.WORDS_PER_KB(WPK), .ROM_WORDS(ROMW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rom_req(rom_req),
    .rom_addr(rom_addr), .rom_ready(rom_ready), .rom_rdata(rom_rdata),
    .dbg_suspend(dbg_suspend), .irq(irq)
  );

  function automatic logic [31:0] rom_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // bit-serial reference: shift the register, feed back on disagreement
  function automatic logic [31:0] ref_crc(input logic [31:0] seed, input logic [31:0] base,
                                          input int n);
    logic [31:0] c, d;
    logic fb;
    c = seed;
    for (int w = 0; w < n; w++) begin
      d = rom_fn(base + 32'(w * 4));
      for (int b = 0; b < 32; b++) begin
        fb = c[31] ^ d[31];
        c  = {c[30:0], 1'b0};
        d  = {d[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  assign rom_ready = stall_on ? ((tick % 3) != 2) : 1'b1;
  always @(posedge clk) begin
    tick <= tick + 1;
    if (rom_req && rom_ready) rom_rdata <= rom_fn(rom_addr);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(4'd3, s);
      if (!s[0]) break;
    end
  endtask

  task automatic start_scan(input logic [6:0] code, input logic [31:0] base,
                            input logic [31:0] seed, input logic [31:0] gold, input bit free);
    wr(4'd1, base);
    wr(4'd2, seed);
    wr(4'd5, gold);
    wr(4'd0, {17'd0, code, 5'd0, free, 1'b0, 1'b1});
  endtask

  localparam int NV = 5;
  localparam logic [6:0]  V_CODE[NV] = '{7'd0, 7'd1, 7'd3, 7'd9, 7'd127};
  localparam logic [31:0] V_BASE[NV] = '{32'h100, 32'h2000, 32'h0, 32'h40, 32'h8000};
  localparam logic [31:0] V_SEED[NV] = '{32'hFFFFFFFF, 32'h0, 32'h12345678, 32'hDEADBEEF, 32'h1};
  localparam bit          V_GOOD[NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_LEN [NV] = '{8, 16, 32, 32, 32};
  localparam bit          V_STALL[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, e, p1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(4'd3, r); check(r == 0, "R7 status after reset", r, 0);
    rd(4'd7, r); check(r == 0, "R9 flags after reset", r, 0);
    rd(4'd4, r); check(r == 0, "R8 result after reset", r, 0);
    check(irq == 0 && rom_req == 0, "R13 irq/req idle after reset", {irq, rom_req}, 0);

    // table of whole scans
    for (int v = 0; v < NV; v++) begin
      stall_on = V_STALL[v];
      e = ref_crc(V_SEED[v], V_BASE[v], V_LEN[v]);
      start_scan(V_CODE[v], V_BASE[v], V_SEED[v], V_GOOD[v] ? e : (e ^ 32'h1), 1'b0);
      rd(4'd0, r); check(r[0] == 0, "R3 start bit reads 0", r, 0);
      rd(4'd3, r); check(r[0] == 1, "R7 run while scanning", r, 1);
      wait_idle();
      rd(4'd4, r); check(r == e, "R11 R1 R2 R13 crc result", r, e);
      rd(4'd3, r);
      check(r[31:16] == 16'(V_LEN[v]), "R1 R2 final position", 32'(r[31:16]), V_LEN[v]);
      check(r[1] == !V_GOOD[v], "R8 check status", 32'(r[1]), 32'(!V_GOOD[v]));
      rd(4'd7, r); check(r[0] == 1, "R9 done flag set", r, 1);
    end
    stall_on = 1'b0;

    // writing 0 to start: nothing starts
    wr(4'd0, 32'h0000_0300);
    rd(4'd3, r); check(r[0] == 0 && r[31:16] == 32, "R3 zero start ignored", r, 32'h0020_0000);

    // halt while idle is ignored
    wr(4'd0, 32'h0000_0302);
    rd(4'd0, r); check(r[1] == 0, "R12 idle halt ignored", r, 32'h300);

    // restart mid-scan with new seed
    start_scan(7'd3, 32'h400, 32'hAAAA5555, 32'h0, 1'b0);
    repeat (10) @(negedge clk);
    wr(4'd2, 32'h0BADF00D);
    wr(4'd0, 32'h0000_0301);
    wait_idle();
    e = ref_crc(32'h0BADF00D, 32'h400, 32);
    rd(4'd4, r); check(r == e, "R4 restart result", r, e);

    // halt and resume
    start_scan(7'd3, 32'h600, 32'h13572468, 32'h0, 1'b0);
    repeat (5) @(negedge clk);
    wr(4'd0, 32'h0000_0302);
    rd(4'd0, r); check(r[1] == 1, "R5 halt bit held", r, 32'h302);
    rd(4'd3, p1);
    repeat (20) @(negedge clk);
    rd(4'd3, r); check(r == p1 && r[0], "R5 frozen while halted", r, p1);
    check(rom_req == 0, "R5 no request while halted", 32'(rom_req), 0);
    wr(4'd0, 32'h0000_0300);
    wait_idle();
    e = ref_crc(32'h13572468, 32'h600, 32);
    rd(4'd4, r); check(r == e, "R5 resumed result", r, e);
    rd(4'd0, r); check(r[1] == 0, "R12 halt clear after finish", r, 32'h300);

    // soft mode debug suspend
    dbg_suspend = 1'b1;
    start_scan(7'd0, 32'h80, 32'h2468ACE0, 32'h0, 1'b0);
    repeat (20) @(negedge clk);
    rd(4'd3, r); check(r[0] == 1 && r[31:16] == 0, "R6 soft suspend holds", r, 1);
    dbg_suspend = 1'b0;
    wait_idle();
    e = ref_crc(32'h2468ACE0, 32'h80, 8);
    rd(4'd4, r); check(r == e, "R6 soft resume result", r, e);

    // free mode ignores suspend
    dbg_suspend = 1'b1;
    start_scan(7'd1, 32'hC0, 32'h55AA55AA, 32'h0, 1'b1);
    wait_idle();
    e = ref_crc(32'h55AA55AA, 32'hC0, 16);
    rd(4'd4, r); check(r == e, "R6 free mode result", r, e);
    dbg_suspend = 1'b0;

    // interrupt scheme
    check(irq == 0, "R9 no irq while disabled", 32'(irq), 0);
    wr(4'd6, 32'h1);
    @(negedge clk);
    check(irq == 1, "R9 irq on enable", 32'(irq), 1);
    wr(4'd8, 32'h1);
    rd(4'd7, r); check(r == 32'h2, "R10 done cleared, global kept", r, 2);
    check(irq == 1, "R10 latch holds", 32'(irq), 1);
    wr(4'd8, 32'h2);
    repeat (3) @(negedge clk);
    check(irq == 0, "R10 global cleared", 32'(irq), 0);
    wr(4'd9, 32'h1);
    @(negedge clk);
    rd(4'd7, r); check(r == 32'h3, "R10 force sets done and irq", r, 3);
    wr(4'd8, 32'h2);
    @(negedge clk);
    check(irq == 1, "R10 global re-fires while done set", 32'(irq), 1);
    wr(4'd8, 32'h3);
    repeat (2) @(negedge clk);
    rd(4'd7, r); check(r == 0 && irq == 0, "R10 clear both", r, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule